// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block watches the already-synchronized clock and data lines of a two-wire SMBus and counts system clock cycles to detect two bus conditions. The first is a clock line held low for too long, which is the classic stuck-bus timeout. The second is both lines resting high, which means the bus has gone idle. The length of each condition is set by a threshold input. A threshold of zero switches that detector off.

The idle condition is reported in two forms. The first is a live status bit that follows the bus and drops as soon as either line falls. It never raises an interrupt. The second is a sticky flag that records that the idle period was reached. The clock-low condition also has a sticky flag. Software clears either sticky flag by pulsing its clear input. A single timeout interrupt output merges the sticky flags under a global interrupt enable. The idle flag also needs its own enable before it can drive the interrupt.

In a typical system the idle threshold is much shorter than the clock-low threshold. The idle flag therefore gets its own enable, so that frequent idle events can be kept out of the interrupt.

Top module: `smb_tmo_monitor`

## Requirements
- R1: While rst_n is low, and in the cycle after it is released, low_flag, idle_live, idle_flag and tmo_irq are all 0.
- R2: Once SCL has been sampled low on low_limit consecutive rising clock edges, low_flag reads 1 after the following rising edge. Any edge at which SCL is sampled high restarts the count from zero.
- R3: When low_limit is 0, low_flag never sets, however long SCL stays low.
- R4: idle_live reads 1 after SCL and SDA have both been sampled high on idle_limit consecutive rising edges. It falls combinationally, within the same cycle, when either line goes low.
- R5: idle_flag sets one rising edge after the idle threshold is reached. It stays set after the lines leave the idle state.
- R6: A 1 on low_flag_clr or idle_flag_clr at a rising edge clears the matching flag. If that flag's set condition is present at the same edge, the flag stays 1 (set wins). With no clear, a set flag holds.
- R7: When idle_limit is 0, idle_live and idle_flag stay 0, however long both lines stay high.
- R8: tmo_irq equals irq_en AND (low_flag OR (idle_irq_en AND idle_flag)). idle_live has no effect on tmo_irq.
- R9: With idle_irq_en at 0, a set idle_flag does not raise tmo_irq. Setting idle_irq_en to 1 raises tmo_irq in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| low_limit | input | CNT_W | SCL-low timeout in clock cycles, 0 disables |
| idle_limit | input | CNT_W | Both-high idle period in clock cycles, 0 disables |
| irq_en | input | 1 | Global interrupt enable |
| idle_irq_en | input | 1 | Enable for the sticky idle flag toward the interrupt |
| low_flag_clr | input | 1 | Write-one clear pulse for low_flag |
| idle_flag_clr | input | 1 | Write-one clear pulse for idle_flag |
| low_flag | output | 1 | Sticky SCL-low timeout flag |
| idle_live | output | 1 | Live bus-idle indicator |
| idle_flag | output | 1 | Sticky bus-idle flag |
| tmo_irq | output | 1 | Combined timeout interrupt |

## Verification
Some properties can be checked on every cycle. The assertions check that a counter hit always leads to its sticky flag on the next edge, and that a flag holds unless it is cleared. They check that a clear without a competing hit takes effect, and that idle_live is never high while a line is low. They also check that the interrupt stays quiet when the global enable is off or no sticky flag is set. Other behaviour only shows over a whole scenario: the exact edge on which each threshold is crossed, a count restarting when SCL pulses high mid-timeout, zero thresholds disabling a detector over long stretches, and the set-wins rule while a saturated condition persists. The bench's cycle-by-cycle scoreboard covers these.

// File: rtl/smb_tmo_pkg.sv
package smb_tmo_pkg;

  typedef struct packed {
    logic scl_low;
    logic bus_idle;
  } tmo_flags_t;

  // Merge sticky flags into the interrupt; the live idle bit is never an input.
  function automatic logic merge_irq(logic glb_en, logic idle_en, tmo_flags_t f);
    return glb_en & (f.scl_low | (idle_en & f.bus_idle));
  endfunction

  // Next value of a sticky flag: a set beats a clear at the same edge.
  function automatic logic sticky_next(logic cur, logic set, logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

endpackage

// File: rtl/smb_tmo_counter.sv
module smb_tmo_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  // Saturating step toward the limit; zero limit keeps the counter parked.
  function automatic logic [CNT_W-1:0] step_count(logic [CNT_W-1:0] c,
                                                  logic [CNT_W-1:0] lim);
    if (lim == '0)      return '0;
    else if (c >= lim)  return c;
    else                return c + 1'b1;
  endfunction

  function automatic logic reached(logic [CNT_W-1:0] c, logic [CNT_W-1:0] lim);
    return (lim != '0) && (c >= lim);
  endfunction

  always_comb begin
    if (run_i) cnt_d = step_count(cnt_q, limit_i);
    else       cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit_o = reached(cnt_q, limit_i);

endmodule

// File: rtl/smb_tmo_sticky.sv
module smb_tmo_sticky
  import smb_tmo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= sticky_next(flag_q, set_i, clr_i);
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/smb_tmo_monitor.sv
module smb_tmo_monitor
  import smb_tmo_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [CNT_W-1:0] low_limit,
  input  logic [CNT_W-1:0] idle_limit,
  input  logic             irq_en,
  input  logic             idle_irq_en,
  input  logic             low_flag_clr,
  input  logic             idle_flag_clr,
  output logic             low_flag,
  output logic             idle_live,
  output logic             idle_flag,
  output logic             tmo_irq
);

  // Named internal events, also used by the bound checker.
  logic       low_run;
  logic       idle_run;
  logic       low_hit;
  logic       idle_hit;
  tmo_flags_t flags;

  assign low_run  = ~scl_in;
  assign idle_run = scl_in & sda_in;

  smb_tmo_counter #(.CNT_W(CNT_W)) u_low_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (low_run),
    .limit_i (low_limit),
    .hit_o   (low_hit)
  );

  smb_tmo_counter #(.CNT_W(CNT_W)) u_idle_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (idle_run),
    .limit_i (idle_limit),
    .hit_o   (idle_hit)
  );

  smb_tmo_sticky u_low_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (low_hit),
    .clr_i  (low_flag_clr),
    .flag_o (flags.scl_low)
  );

  smb_tmo_sticky u_idle_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (idle_hit),
    .clr_i  (idle_flag_clr),
    .flag_o (flags.bus_idle)
  );

  // Live status drops the moment either line leaves the high state.
  assign idle_live = idle_hit & idle_run;
  assign low_flag  = flags.scl_low;
  assign idle_flag = flags.bus_idle;
  assign tmo_irq   = merge_irq(irq_en, idle_irq_en, flags);

endmodule

// File: rtl/smb_tmo_monitor_sva.sv
module smb_tmo_monitor_sva #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_in,
  input logic             sda_in,
  input logic [CNT_W-1:0] low_limit,
  input logic [CNT_W-1:0] idle_limit,
  input logic             irq_en,
  input logic             idle_irq_en,
  input logic             low_flag_clr,
  input logic             idle_flag_clr,
  input logic             low_hit,
  input logic             idle_hit,
  input logic             low_flag,
  input logic             idle_live,
  input logic             idle_flag,
  input logic             tmo_irq
);

  assert_low_hit_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    low_hit |=> low_flag);

  assert_low_off_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (low_limit == '0) |-> !low_hit);

  assert_live_needs_lines_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idle_live |-> (scl_in && sda_in));

  assert_idle_hit_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idle_hit |=> idle_flag);

  assert_low_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (low_flag_clr && !low_hit) |=> !low_flag);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_flag && !idle_flag_clr) |=> idle_flag);

  assert_idle_off_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_limit == '0) |-> !idle_live);

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !tmo_irq);

  assert_irq_ignores_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!low_flag && !idle_flag) |-> !tmo_irq);

  assert_idle_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!low_flag && !idle_irq_en) |-> !tmo_irq);

endmodule

bind smb_tmo_monitor smb_tmo_monitor_sva #(.CNT_W(CNT_W)) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .scl_in        (scl_in),
  .sda_in        (sda_in),
  .low_limit     (low_limit),
  .idle_limit    (idle_limit),
  .irq_en        (irq_en),
  .idle_irq_en   (idle_irq_en),
  .low_flag_clr  (low_flag_clr),
  .idle_flag_clr (idle_flag_clr),
  .low_hit       (low_hit),
  .idle_hit      (idle_hit),
  .low_flag      (low_flag),
  .idle_live     (idle_live),
  .idle_flag     (idle_flag),
  .tmo_irq       (tmo_irq)
);

// File: tb/smb_tmo_monitor_tb.sv
`timescale 1ns/1ps
module smb_tmo_monitor_tb;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         scl = 1'b1, sda = 1'b0;
  logic [W-1:0] lo_lim = 16'd20, id_lim = 16'd5;
  logic         irq_en = 1'b1, id_en = 1'b0;
  logic         lclr = 1'b0, iclr = 1'b0;
  logic         low_flag, idle_live, idle_flag, tmo_irq;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic lo;
    logic live;
    logic idf;
    logic irq;
  } exp_t;
  exp_t q[$];

  // Reference state: run lengths of each bus condition, plus the sticky flags.
  int   lo_run = 0, hh_run = 0;
  logic m_lo = 0, m_id = 0;

  always #2 clk = ~clk;

  smb_tmo_monitor #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .low_limit(lo_lim), .idle_limit(id_lim), .irq_en(irq_en),
    .idle_irq_en(id_en), .low_flag_clr(lclr), .idle_flag_clr(iclr),
    .low_flag(low_flag), .idle_live(idle_live), .idle_flag(idle_flag),
    .tmo_irq(tmo_irq)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // Driver: set inputs for one cycle and push the outputs expected after the edge.
  task automatic step(logic s_scl, logic s_sda, logic s_lclr, logic s_iclr);
    exp_t e;
    bit lo_was, hh_was;
    @(negedge clk);
    scl = s_scl; sda = s_sda; lclr = s_lclr; iclr = s_iclr;
    lo_was = (lo_lim != 0) && (lo_run >= int'(lo_lim));
    hh_was = (id_lim != 0) && (hh_run >= int'(id_lim));
    if (lo_was) m_lo = 1; else if (s_lclr) m_lo = 0;
    if (hh_was) m_id = 1; else if (s_iclr) m_id = 0;
    if (s_scl || lo_lim == 0) lo_run = 0;
    else if (lo_run < int'(lo_lim)) lo_run++;
    if (!(s_scl && s_sda) || id_lim == 0) hh_run = 0;
    else if (hh_run < int'(id_lim)) hh_run++;
    e.lo   = m_lo;
    e.idf  = m_id;
    e.live = (id_lim != 0) && (hh_run >= int'(id_lim)) && s_scl && s_sda;
    e.irq  = irq_en && (m_lo || (id_en && m_id));
    q.push_back(e);
  endtask

  task automatic hold(logic s_scl, logic s_sda, int n);
    for (int i = 0; i < n; i++) step(s_scl, s_sda, 1'b0, 1'b0);
  endtask

  // Monitor: compare one expected item one step after every rising edge.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check("R2/R3 low_flag", low_flag, e.lo);
      check("R4/R7 idle_live", idle_live, e.live);
      check("R5/R6 idle_flag", idle_flag, e.idf);
      check("R8/R9 tmo_irq", tmo_irq, e.irq);
    end
  end

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #9;
    // R1: outputs quiet in reset
    check("R1 low_flag", low_flag, 1'b0);
    check("R1 idle_live", idle_live, 1'b0);
    check("R1 idle_flag", idle_flag, 1'b0);
    check("R1 tmo_irq", tmo_irq, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;           // scl high, sda low: no counter moves
    @(posedge clk); #1;
    check("R1 low_flag after release", low_flag, 1'b0);
    check("R1 tmo_irq after release", tmo_irq, 1'b0);

    // R4 R5: idle threshold, idle flag not enabled into irq (R9)
    hold(1, 1, 8);
    // R4: live drops at once, R5: flag stays
    hold(1, 0, 3);
    // R9: enabling idle flag raises irq
    @(negedge clk); id_en = 1'b1;
    hold(1, 0, 2);
    // R6: clear idle flag
    step(1, 0, 0, 1);
    hold(1, 0, 2);
    // R6: set wins over clear while lines stay idle
    hold(1, 1, 7);
    step(1, 1, 0, 1);
    step(1, 1, 0, 1);
    hold(0, 1, 1);
    step(0, 1, 0, 1);
    hold(1, 0, 2);

    // R2: SCL low restart, then full timeout
    hold(0, 0, 12);
    hold(1, 0, 1);
    hold(0, 0, 24);
    // R6: clear while still low, set wins
    step(0, 0, 1, 0);
    hold(1, 0, 1);
    step(1, 0, 1, 0);
    hold(1, 0, 2);
    // R8: global enable off masks irq
    @(negedge clk); irq_en = 1'b0;
    hold(0, 0, 24);
    @(negedge clk); irq_en = 1'b1;
    hold(0, 0, 2);
    step(1, 0, 1, 0);
    hold(1, 0, 1);

    // R3: zero low limit disables
    @(negedge clk); lo_lim = '0;
    hold(0, 0, 40);
    // R7: zero idle limit disables
    @(negedge clk); id_lim = '0;
    hold(1, 1, 30);
    hold(1, 0, 2);

    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule